// File: doc/BRIEF.md
# Multi-Rate Phased Clock-Enable Controller

This block drives the enable pins of a datapath that runs at several effective rates on one fast base clock. It produces four one-cycle strobes. The first is a full-rate enable. The second is a medium-rate enable that fires once every `DIV_A` enabled cycles. The last two are slow-rate enables that fire once every `DIV_B` enabled cycles, one on the final phase and one on phase 1. With a 50 MHz base clock and the defaults (50 and 200), the medium rate is 1 MHz and the slow rate is 250 kHz.

The block uses two counters. A prescale counter counts modulo `DIV_A`. An epoch counter counts modulo `DIV_B/DIV_A` and advances when the prescale counter wraps. Together they form the slow phase, so the medium and slow strobes keep a fixed phase relation. Both counters advance only on cycles where the global enable `ce_in` is high. Every divided strobe is the AND of `ce_in` with a registered phase flag, so no counter decode logic sits between a flop and an output.

Elaboration stops if `DIV_A` is less than 2 or if `DIV_B` is not a whole multiple of `DIV_A`.

Top module: `rate_strobe_gen`

## Requirements
- R1: `ce_full` equals `ce_in` in the same cycle, with no register in the path.
- R2: Let n be the number of cycles with `ce_in` high since reset was last released, counting from 0. `en_mid_last` is high exactly on the enabled cycles where n mod `DIV_A` equals `DIV_A-1`.
- R3: `en_slow_last` is high exactly on the enabled cycles where n mod `DIV_B` equals `DIV_B-1`.
- R4: `en_slow_ph1` is high exactly on the enabled cycles where n mod `DIV_B` equals 1.
- R5: While `ce_in` is low, all three divided strobes are low and the phase does not advance. The next enabled cycle resumes at the phase that was held.
- R6: A synchronous reset, applied at any phase, returns n to 0. On the first enabled cycle after reset, all divided strobes are low.
- R7: Every `en_slow_last` pulse coincides with an `en_mid_last` pulse.
- R8: While `ce_in` stays high, a divided strobe is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_in | input | 1 | Global enable; gates all counting and all strobes |
| ce_full | output | 1 | Full-rate enable, equal to `ce_in` |
| en_mid_last | output | 1 | Divide-by-`DIV_A` strobe on the last phase |
| en_slow_last | output | 1 | Divide-by-`DIV_B` strobe on the last phase |
| en_slow_ph1 | output | 1 | Divide-by-`DIV_B` strobe on phase 1 |

## Verification
Two pairs of functions can fall in the same cycle.

The medium-rate and slow-rate last-phase strobes must fire together on every `DIV_B/DIV_A`-th medium pulse. Long runs with `ce_in` held high, and randomly gated runs, cross that boundary many times. Each coincidence is judged against a counter of enabled cycles kept in the bench.

A low `ce_in` can also fall on the very cycle that a last phase is due. A directed case parks the phase at `DIV_A-1` and holds the enable low for many cycles. The strobe must stay low throughout and then fire on the first enabled cycle. A reset applied in the middle of a slow period is checked in the same way.

// File: rtl/rate_strobe_pkg.sv
package rate_strobe_pkg;
  // Width of a counter that holds values 0..n-1 (never less than 1 bit).
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int MOD = 50,
  localparam int W = rate_strobe_pkg::cnt_width(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] cnt_d
);
  logic [W-1:0] cnt_q;

  always_comb begin
    if (!adv)                      cnt_d = cnt_q;
    else if (cnt_q == W'(MOD - 1)) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/phase_flag.sv
module phase_flag #(
  parameter int AW    = 6,
  parameter int EW    = 2,
  parameter int A_TGT = 0,
  parameter int E_TGT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] a_next,
  input  logic [EW-1:0] e_next,
  output logic          flag_q
);
  // Registered decode of the next phase: high while the phase equals the target.
  always_ff @(posedge clk) begin
    if (rst) flag_q <= (A_TGT == 0) && (E_TGT == 0);
    else     flag_q <= (a_next == AW'(A_TGT)) && (e_next == EW'(E_TGT));
  end
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen #(
  parameter int DIV_A = 50,
  parameter int DIV_B = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_in,
  output logic ce_full,
  output logic en_mid_last,
  output logic en_slow_last,
  output logic en_slow_ph1
);
  localparam int EPOCHS = DIV_B / DIV_A;
  localparam int AW     = rate_strobe_pkg::cnt_width(DIV_A);
  localparam int EW     = rate_strobe_pkg::cnt_width(EPOCHS);

  // Parameter legality: phase 1 needs DIV_A >= 2, and alignment needs an integer ratio.
  generate
    if (DIV_A < 2) begin : g_bad_a
      $error("rate_strobe_gen: DIV_A must be at least 2");
    end
    if ((DIV_B < DIV_A) || (DIV_B % DIV_A != 0)) begin : g_bad_b
      $error("rate_strobe_gen: DIV_B must be a whole multiple of DIV_A");
    end
  endgenerate

  logic [AW-1:0] a_d;
  logic [EW-1:0] e_d;
  logic          a_wrap;
  logic          f_mid_last, f_slow_last, f_slow_ph1;

  phase_counter #(.MOD(DIV_A)) u_pre (
    .clk(clk), .rst(rst), .adv(ce_in), .cnt_d(a_d)
  );

  // The prescale counter wraps when it advances and its next value is 0.
  assign a_wrap = ce_in && (a_d == '0);

  generate
    if (EPOCHS > 1) begin : g_epoch
      phase_counter #(.MOD(EPOCHS)) u_epoch (
        .clk(clk), .rst(rst), .adv(a_wrap), .cnt_d(e_d)
      );
    end else begin : g_no_epoch
      assign e_d = '0;
    end
  endgenerate

  phase_flag #(.AW(AW), .EW(EW), .A_TGT(DIV_A - 1), .E_TGT(0)) u_f_mid (
    .clk(clk), .rst(rst), .a_next(a_d), .e_next('0), .flag_q(f_mid_last)
  );
  phase_flag #(.AW(AW), .EW(EW), .A_TGT(DIV_A - 1), .E_TGT(EPOCHS - 1)) u_f_slast (
    .clk(clk), .rst(rst), .a_next(a_d), .e_next(e_d), .flag_q(f_slow_last)
  );
  phase_flag #(.AW(AW), .EW(EW), .A_TGT(1), .E_TGT(0)) u_f_sph1 (
    .clk(clk), .rst(rst), .a_next(a_d), .e_next(e_d), .flag_q(f_slow_ph1)
  );

  assign ce_full      = ce_in;
  assign en_mid_last  = ce_in & f_mid_last;
  assign en_slow_last = ce_in & f_slow_last;
  assign en_slow_ph1  = ce_in & f_slow_ph1;
endmodule

// File: rtl/rate_strobe_chk.sv
module rate_strobe_chk #(
  parameter int DIV_A = 50,
  parameter int DIV_B = 200
) (
  input logic clk,
  input logic rst,
  input logic ce_in,
  input logic ce_full,
  input logic en_mid_last,
  input logic en_slow_last,
  input logic en_slow_ph1
);
  localparam int KW = rate_strobe_pkg::cnt_width(DIV_B);
  logic [KW-1:0] seen_k;

  // Independent count of enabled cycles since reset, modulo DIV_B.
  always_ff @(posedge clk) begin
    if (rst)        seen_k <= '0;
    else if (ce_in) seen_k <= (seen_k == KW'(DIV_B - 1)) ? '0 : seen_k + 1'b1;
  end

  assert_mid_phase_R2: assert property (@(posedge clk) disable iff (rst)
    en_mid_last == (ce_in && ((int'(seen_k) % DIV_A) == DIV_A - 1)));
  assert_slow_phase_R3: assert property (@(posedge clk) disable iff (rst)
    en_slow_last == (ce_in && (int'(seen_k) == DIV_B - 1)));
  assert_ph1_phase_R4: assert property (@(posedge clk) disable iff (rst)
    en_slow_ph1 == (ce_in && (int'(seen_k) == 1)));
  assert_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (en_mid_last || en_slow_last || en_slow_ph1) |-> ce_full);
  assert_post_reset_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(en_mid_last || en_slow_last || en_slow_ph1));
  assert_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    en_slow_last |-> en_mid_last);
  assert_single_R8: assert property (@(posedge clk) disable iff (rst)
    (en_mid_last && ce_in) |=> !en_mid_last);
endmodule

bind rate_strobe_gen rate_strobe_chk #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_chk (.*);

// File: tb/tb_rate_strobe_gen.sv
`timescale 1ns/1ps
module tb_rate_strobe_gen;
  localparam int A = 50;
  localparam int B = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_in = 1'b0;
  logic ce_full, en_mid_last, en_slow_last, en_slow_ph1;

  int checks = 0;
  int failures = 0;
  int k = 0;
  bit just_reset = 1'b0;
  bit prev_mid = 1'b0, prev_sl = 1'b0, prev_p1 = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rate_strobe_gen #(.DIV_A(A), .DIV_B(B)) dut (
    .clk(clk), .rst(rst), .ce_in(ce_in), .ce_full(ce_full),
    .en_mid_last(en_mid_last), .en_slow_last(en_slow_last), .en_slow_ph1(en_slow_ph1)
  );

  function automatic bit exp_mid(input int n, input bit ce);
    return ce && ((n % A) == A - 1);
  endfunction
  function automatic bit exp_slast(input int n, input bit ce);
    return ce && (n == B - 1);
  endfunction
  function automatic bit exp_ph1(input int n, input bit ce);
    return ce && (n == 1);
  endfunction

  task automatic chk(input logic act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b (n=%0d)", tag, what, act, exp, k);
    end
  endtask

  task automatic step(input bit r, input bit ce);
    string t2, t3, t4;
    @(negedge clk);
    rst = r;
    ce_in = ce;
    #1;
    chk(ce_full, ce, "R1", "ce_full");
    t2 = just_reset ? "R6" : (ce ? "R2" : "R5");
    t3 = just_reset ? "R6" : (ce ? "R3" : "R5");
    t4 = just_reset ? "R6" : (ce ? "R4" : "R5");
    if (!r || k != 0) begin
      chk(en_mid_last,  exp_mid(k, ce),   t2, "en_mid_last");
      chk(en_slow_last, exp_slast(k, ce), t3, "en_slow_last");
      chk(en_slow_ph1,  exp_ph1(k, ce),   t4, "en_slow_ph1");
    end
    if (exp_slast(k, ce)) chk(en_mid_last, 1'b1, "R7", "coincident mid strobe");
    if (ce && prev_mid) chk(en_mid_last, 1'b0, "R8", "en_mid_last repeat");
    if (ce && prev_sl)  chk(en_slow_last, 1'b0, "R8", "en_slow_last repeat");
    if (ce && prev_p1)  chk(en_slow_ph1, 1'b0, "R8", "en_slow_ph1 repeat");
    prev_mid = en_mid_last;
    prev_sl  = en_slow_last;
    prev_p1  = en_slow_ph1;
    if (ce && !r) just_reset = 1'b0;
    @(posedge clk);
    if (r) begin
      k = 0;
      just_reset = 1'b1;
    end else if (ce) begin
      k = (k + 1) % B;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step(1'b1, 1'b0);
    // R6: first enabled cycles after reset carry no divided strobe.
    repeat (450) step(1'b0, 1'b1);
    // R5: park at the last medium phase, hold enable low, then resume.
    while ((k % A) != A - 1) step(1'b0, 1'b1);
    repeat (25) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    // R5 on the slow last phase as well.
    while (k != B - 1) step(1'b0, 1'b1);
    repeat (7) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    // R6: reset in the middle of a slow period.
    while (k != 120) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    repeat (260) step(1'b0, 1'b1);
    // Randomly gated enable.
    for (int i = 0; i < 1800; i++) step(1'b0, ($urandom % 4) != 0);
    for (int i = 0; i < 600; i++) step(($urandom % 300) == 0, ($urandom % 2) != 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule